// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block answers the identification and status commands that a host issues to a serial NOR flash. It works at byte granularity. A separate shifter delivers each byte received from the host on `rx_byte`, with a one-cycle `rx_valid` strobe, and loads `tx_byte` as the byte to return in the next byte slot. An active-low select, `cs_n`, frames every transaction. Raising `cs_n` returns the responder to its idle state and resets every response pointer.

Three commands return data. The identity read (0x9F) returns manufacturer, memory type and device codes. The status read (0x05) returns the status byte for as long as select stays low. The electronic ID read (0x90) takes two dummy bytes and a selector byte, then returns the two ID codes in the order the selector picks. Two single-byte commands control the write-enable latch: enable (0x06) and disable (0x04). The write-in-progress flag comes from the `wip` input. The ID codes and the fixed upper status bits are parameters. The ID defaults are 0xC2, 0x20 and 0x17.

The controller is a state machine with six states:
- `ST_IDLE`: waits for an opcode.
- `ST_RDID`: identity read.
- `ST_RDSR`: status read.
- `ST_REMS`: electronic ID read.
- `ST_SINGLE`: a latch command was received alone.
- `ST_DISCARD`: unsupported opcode, or extra bytes after a latch command.

Transitions:
- A high `cs_n` sends any state to `ST_IDLE`.
- In `ST_IDLE`, a byte goes to the state its opcode selects. Any other opcode goes to `ST_DISCARD`.
- In `ST_SINGLE`, a further byte goes to `ST_DISCARD`.
- The other states hold until `cs_n` rises.

Top module: `spi_id_responder`

## Requirements
- R1: During reset, and in every cycle after a cycle in which `cs_n` was sampled high, `tx_byte` is 0xFF. A transaction that is cut short and started again begins from its first response byte.
- R2: After opcode 0x9F, the successive slots return MFR_ID, MEM_TYPE and DEV_ID, in that order. Every slot after those returns 0xFF.
- R3: After opcode 0x05, every slot returns the status byte until `cs_n` rises. The byte follows the current `wip` and latch values.
- R4: Status byte layout: bit 0 is `wip`, bit 1 is the write-enable latch, bits 5:2 are SR_BP[3:0], bit 6 is SR_CP and bit 7 is SR_SRWD.
- R5: After opcode 0x90, the three slots for the two dummy bytes and the selector return 0xFF. A selector of 0x00 then yields MFR_ID followed by DEV_ID.
- R6: After opcode 0x90, any selector other than 0x00 yields DEV_ID followed by MFR_ID. Every later slot returns 0xFF.
- R7: A transaction holding only the byte 0x06 sets the write-enable latch when `cs_n` rises.
- R8: A transaction holding only the byte 0x04 clears the write-enable latch when `cs_n` rises.
- R9: The latch is left unchanged if more bytes follow 0x06 or 0x04 in the same transaction. It never changes while `cs_n` is low.
- R10: Every slot of an unsupported opcode returns 0xFF. Bytes strobed while `cs_n` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Transaction select, active low |
| rx_valid | input | 1 | One-cycle strobe: a host byte is on `rx_byte` |
| rx_byte | input | 8 | Byte received from the host |
| wip | input | 1 | Write-in-progress flag reported in status bit 0 |
| tx_byte | output | 8 | Byte to return in the next byte slot |

## Verification
The bench builds the responder with MFR_ID 0x3C, MEM_TYPE 0x41, DEV_ID 0x96, SR_BP 4'b1010, SR_CP 1 and SR_SRWD 0. Each ID code is distinct from the others and from 0x00 and 0xFF, so a swapped or repeated ID slot shows up as a wrong value. The asymmetric upper status bits expose any shift or swap of the status fields. A behavioural model built on a response queue predicts `tx_byte` in every cycle while the bench toggles `wip` and runs cut-short, padded and unsupported transactions.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_REMS  = 8'h90;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] FILL     = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDID,
        ST_RDSR,
        ST_REMS,
        ST_SINGLE,
        ST_DISCARD
    } sid_state_e;

endpackage

// File: rtl/sid_fsm.sv
module sid_fsm
    import spi_id_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output sid_state_e       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             dev_first_o,
    output logic             wel_set_o,
    output logic             wel_clr_o
);
    localparam logic [IDX_W-1:0] RDID_LAST = IDX_W'(3);
    localparam logic [IDX_W-1:0] REMS_SEL  = IDX_W'(2);
    localparam logic [IDX_W-1:0] REMS_LAST = IDX_W'(5);

    sid_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             devf_q, devf_d;
    logic             set_q, set_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            devf_q <= 1'b0;
            set_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            devf_q <= devf_d;
            set_q  <= set_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        idx_d  = idx_q;
        devf_d = devf_q;
        set_d  = set_q;
        if (cs_n) begin
            st_d  = ST_IDLE;
            idx_d = '0;
        end else if (rx_valid) begin
            unique case (st_q)
                ST_IDLE: begin
                    idx_d = '0;
                    case (rx_byte)
                        OP_RDID: st_d = ST_RDID;
                        OP_RDSR: st_d = ST_RDSR;
                        OP_REMS: st_d = ST_REMS;
                        OP_WREN: begin st_d = ST_SINGLE; set_d = 1'b1; end
                        OP_WRDI: begin st_d = ST_SINGLE; set_d = 1'b0; end
                        default: st_d = ST_DISCARD;
                    endcase
                end
                ST_RDID: begin
                    if (idx_q != RDID_LAST) idx_d = idx_q + IDX_W'(1);
                end
                ST_REMS: begin
                    if (idx_q == REMS_SEL) devf_d = (rx_byte != 8'h00);
                    if (idx_q != REMS_LAST) idx_d = idx_q + IDX_W'(1);
                end
                ST_SINGLE:  st_d = ST_DISCARD;
                ST_RDSR:    st_d = ST_RDSR;
                ST_DISCARD: st_d = ST_DISCARD;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        state_o     = st_q;
        idx_o       = idx_q;
        dev_first_o = devf_q;
        wel_set_o   = cs_n && (st_q == ST_SINGLE) && set_q;
        wel_clr_o   = cs_n && (st_q == ST_SINGLE) && !set_q;
    end

endmodule

// File: rtl/sid_wel.sv
module sid_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wel_o <= 1'b0;
        else if (set_i) wel_o <= 1'b1;
        else if (clr_i) wel_o <= 1'b0;
    end
endmodule

// File: rtl/sid_txmux.sv
module sid_txmux
    import spi_id_pkg::*;
#(
    parameter int         IDX_W    = 3,
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_ID   = 8'h17
) (
    input  sid_state_e       state_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             dev_first_i,
    input  logic [7:0]       status_i,
    output logic [7:0]       tx_o
);
    localparam logic [IDX_W-1:0] FIRST_ID = IDX_W'(3);
    localparam logic [IDX_W-1:0] SECOND_ID = IDX_W'(4);

    always_comb begin
        tx_o = FILL;
        unique case (state_i)
            ST_RDID: begin
                case (idx_i)
                    IDX_W'(0): tx_o = MFR_ID;
                    IDX_W'(1): tx_o = MEM_TYPE;
                    IDX_W'(2): tx_o = DEV_ID;
                    default:   tx_o = FILL;
                endcase
            end
            ST_REMS: begin
                if (idx_i == FIRST_ID)       tx_o = dev_first_i ? DEV_ID : MFR_ID;
                else if (idx_i == SECOND_ID) tx_o = dev_first_i ? MFR_ID : DEV_ID;
                else                         tx_o = FILL;
            end
            ST_RDSR: tx_o = status_i;
            ST_IDLE, ST_SINGLE, ST_DISCARD: tx_o = FILL;
            default: tx_o = FILL;
        endcase
    end
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
    import spi_id_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_ID   = 8'h17,
    parameter logic [3:0] SR_BP    = 4'h0,
    parameter bit         SR_CP    = 1'b0,
    parameter bit         SR_SRWD  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       wip,
    output logic [7:0] tx_byte
);
    localparam int IDX_W = 3;

    sid_state_e       state_w;
    logic [IDX_W-1:0] idx_w;
    logic             devf_w, set_w, clr_w, wel_w;
    logic [7:0]       status_w;

    sid_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .state_o(state_w), .idx_o(idx_w),
        .dev_first_o(devf_w), .wel_set_o(set_w), .wel_clr_o(clr_w)
    );

    sid_wel u_wel (
        .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .wel_o(wel_w)
    );

    assign status_w = {SR_SRWD, SR_CP, SR_BP, wel_w, wip};

    sid_txmux #(
        .IDX_W(IDX_W), .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .DEV_ID(DEV_ID)
    ) u_mux (
        .state_i(state_w), .idx_i(idx_w), .dev_first_i(devf_w),
        .status_i(status_w), .tx_o(tx_byte)
    );
endmodule

// File: rtl/sid_checker.sv
module sid_checker
    import spi_id_pkg::*;
#(
    parameter logic [7:0] MFR_ID = 8'hC2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       wip,
    input logic [7:0] tx_byte,
    input sid_state_e st,
    input logic       wel
);
    // R1
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> tx_byte == 8'hFF);

    // R2
    rdid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && st == ST_IDLE && rx_byte == OP_RDID) |=> tx_byte == MFR_ID);

    // R3
    rdsr_wip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid && st == ST_IDLE && rx_byte == OP_RDSR) |=> tx_byte[0] == wip);

    // R7
    wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> ($past(cs_n) && $past(st == ST_SINGLE)));

    // R9
    wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> $stable(wel));

    // R10
    discard_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DISCARD) |-> tx_byte == 8'hFF);
endmodule

bind spi_id_responder sid_checker #(.MFR_ID(MFR_ID)) u_sid_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .wip(wip), .tx_byte(tx_byte),
    .st(state_w), .wel(wel_w)
);

// File: tb/test_spi_id_responder.sv
`timescale 1ns/1ps
module test_spi_id_responder;
    localparam logic [7:0] M = 8'h3C;
    localparam logic [7:0] T = 8'h41;
    localparam logic [7:0] D = 8'h96;
    localparam logic [3:0] BP = 4'b1010;
    localparam bit CP = 1'b1;
    localparam bit SRWD = 1'b0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic wip = 1'b0;
    logic [7:0] tx_byte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    spi_id_responder #(
        .MFR_ID(M), .MEM_TYPE(T), .DEV_ID(D),
        .SR_BP(BP), .SR_CP(CP), .SR_SRWD(SRWD)
    ) i_spi_id_responder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wip(wip), .tx_byte(tx_byte)
    );

    always #2.5 clk = ~clk;

    // Behavioural model: a queue of pending response bytes per transaction
    int mode = 0;   // 0 idle, 1 id read, 2 status, 3 elec id, 4 single, 5 discard
    int nafter = 0;
    logic [7:0] q[$];
    logic m_wel = 1'b0;
    logic single_en = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0; nafter = 0; q.delete(); m_wel = 1'b0;
        end else if (cs_n) begin
            if (mode == 4) m_wel = single_en;
            mode = 0; nafter = 0; q.delete();
        end else if (rx_valid) begin
            case (mode)
                0: begin
                    case (rx_byte)
                        8'h9F: begin mode = 1; q = '{M, T, D}; end
                        8'h05: mode = 2;
                        8'h90: begin mode = 3; nafter = 0; end
                        8'h06: begin mode = 4; single_en = 1'b1; end
                        8'h04: begin mode = 4; single_en = 1'b0; end
                        default: mode = 5;
                    endcase
                end
                1: if (q.size() > 0) void'(q.pop_front());
                3: begin
                    nafter++;
                    if (q.size() > 0) void'(q.pop_front());
                    if (nafter == 3) begin
                        if (rx_byte == 8'h00) q = '{M, D};
                        else q = '{D, M};
                    end
                end
                4: mode = 5;
                default: ;
            endcase
        end
    end

    function automatic logic [7:0] expected();
        if (mode == 2) return {SRWD, CP, BP, m_wel, wip};
        if ((mode == 1 || mode == 3) && q.size() > 0) return q[0];
        return 8'hFF;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] e;
            e = expected();
            checks++;
            if (tx_byte !== e) begin
                errors++;
                $display("FAIL %s tx_byte=%02h expected=%02h t=%0t", cur_req, tx_byte, e, $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic put_byte(logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b; tick();
        rx_valid = 1'b0; tick();
    endtask

    task automatic open_txn();  cs_n = 1'b0; tick(); endtask
    task automatic close_txn(); cs_n = 1'b1; tick(2); endtask

    initial begin
        cur_req = "R1";
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R2: identity read, one extra slot of fill
        cur_req = "R2";
        open_txn();
        put_byte(8'h9F);
        repeat (4) put_byte(8'h00);
        close_txn();

        // R3 R4: status repeats and follows wip
        cur_req = "R3";
        open_txn();
        put_byte(8'h05);
        put_byte(8'h00);
        wip = 1'b1; tick();
        put_byte(8'h00);
        wip = 1'b0; tick();
        cur_req = "R4";
        put_byte(8'h00);
        close_txn();

        // R7: lone enable sets the latch
        cur_req = "R7";
        open_txn(); put_byte(8'h06); close_txn();
        open_txn(); put_byte(8'h05); put_byte(8'h00); close_txn();

        // R9: disable followed by extra byte keeps latch set
        cur_req = "R9";
        open_txn(); put_byte(8'h04); put_byte(8'h04); close_txn();
        open_txn(); put_byte(8'h05); put_byte(8'h00); close_txn();

        // R8: lone disable clears
        cur_req = "R8";
        open_txn(); put_byte(8'h04); close_txn();
        open_txn(); put_byte(8'h05); put_byte(8'h00); close_txn();

        // R9: enable with extra byte does not set
        cur_req = "R9";
        open_txn(); put_byte(8'h06); put_byte(8'h11); close_txn();
        open_txn(); put_byte(8'h05); close_txn();

        // R5: selector zero
        cur_req = "R5";
        open_txn();
        put_byte(8'h90); put_byte(8'h00); put_byte(8'h00); put_byte(8'h00);
        put_byte(8'h00); put_byte(8'h00);
        close_txn();

        // R6: nonzero selector, extra slots
        cur_req = "R6";
        open_txn();
        put_byte(8'h90); put_byte(8'hAA); put_byte(8'h55); put_byte(8'h01);
        repeat (3) put_byte(8'h00);
        close_txn();

        // R10: unsupported opcode, and strobes while deselected
        cur_req = "R10";
        open_txn(); put_byte(8'hAB); repeat (3) put_byte(8'h9F); close_txn();
        put_byte(8'h06); put_byte(8'h9F);
        tick(2);
        open_txn(); put_byte(8'h05); close_txn();

        // R1: cut-short identity read restarts from the first byte
        cur_req = "R1";
        open_txn(); put_byte(8'h9F); put_byte(8'h00); close_txn();
        open_txn(); put_byte(8'h9F); put_byte(8'h00); put_byte(8'h00); close_txn();

        tick(3);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule